// File: doc/BRIEF.md
# Controller status register with set and clear strobes

This block keeps the status state of a serial controller: an operational-mode bit, a master-select bit and six sticky error flags (mode error, transmit overflow, receive overflow, abort, transmit underflow, receive underflow). Software never writes the status word directly. Instead it writes a write-only strobe word in which every status bit owns one bit that sets it and another that clears it. Bits left at zero in that word leave their targets untouched, so one write can change several status bits at once without a read-modify-write sequence.

Hardware error sources arrive as single-cycle pulses. Five of them are gated by an error-enable register that software can write and read back. The mode-error source is always allowed through. A flag that has been set stays set until software clears it, and the error interrupt output is high while any error flag is set. The enable bit selects between configuration mode (0) and operational mode (1), and that bit is brought out as a port.

The bus side is a one-bit address with a write strobe and a combinational read path. Address 0 holds the error-enable register. Address 1 reads the status word and takes strobe writes.

Top module: `status_strobe_regs`

## Requirements
- R1: After reset, the status word, the error-enable register, `opMode`, `masterSel` and `errIrq` are all 0.
- R2: A strobe write (address 1) with bit1 set makes status bit0 and `opMode` 1 from the next cycle. Bit0 set clears them. Value 0 means configuration mode and value 1 means operational mode.
- R3: A strobe write with bit3 set makes status bit1 and `masterSel` 1. Bit2 set clears them.
- R4: Error strobe positions, given as set/clear strobe bit and then status bit: mode error 7/6 to status 7, transmit overflow 12/8 to status 8, receive overflow 13/9 to status 9, abort 14/10 to status 10, transmit underflow 15/11 to status 11, receive underflow 5/4 to status 12.
- R5: When the set and clear strobes for the same status bit are written together, the bit ends up cleared.
- R6: All strobe bits in one write act in the same cycle.
- R7: A hardware error pulse sets its flag only if its enable bit is 1 in the error-enable register. The enable bits are: bit8 transmit overflow, bit9 receive overflow, bit10 abort, bit11 transmit underflow, bit12 receive underflow. A mode-error pulse always sets its flag.
- R8: A permitted hardware error pulse in the same cycle as a software clear of that flag leaves the flag set.
- R9: `errIrq` is 1 exactly while at least one of the six error flags is set.
- R10: Reading address 0 returns the error-enable register, which has only bits 8 to 12 implemented (all other bits read 0). Reading address 1 returns the status word, with status bit13 following the `busyIn` input.
- R11: Error flags are sticky. They keep their value after the event pulse ends, and a strobe write whose relevant bits are 0 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | 1 | 0: error-enable register, 1: status read / strobe write |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data |
| busyIn | input | 1 | Busy indication shown in status bit13 |
| evRxUnder | input | 1 | Receive underflow event pulse |
| evTxUnder | input | 1 | Transmit underflow event pulse |
| evAbort | input | 1 | Abort event pulse |
| evRxOver | input | 1 | Receive overflow event pulse |
| evTxOver | input | 1 | Transmit overflow event pulse |
| evMode | input | 1 | Mode error event pulse |
| opMode | output | 1 | 1 in operational mode, 0 in configuration mode |
| masterSel | output | 1 | Master-select bit |
| errIrq | output | 1 | Error interrupt, high while any error flag is set |

## Verification
The checker watches every cycle for these properties:
- Error flags never drop unless a strobe write is present.
- Flags change only through a strobe write or a permitted event.
- A permitted event always leaves its flag set.
- A clear strobe wins over a set strobe for the mode-error bit.
- A clear-enable strobe always ends operational mode.

The bit positions of each strobe, the gating by individual enable bits, the read-back map, the busy reflection and the interrupt level are shown only by the bench's directed scenarios. Each scenario compares the read-back words against values worked out from the requirements.

// File: rtl/stflag_pkg.sv
package stflag_pkg;
  localparam int ERR_N        = 6;
  localparam int E_MODE       = 0;
  localparam int E_TXO        = 1;
  localparam int E_RXO        = 2;
  localparam int E_ABT        = 3;
  localparam int E_TXU        = 4;
  localparam int E_RXU        = 5;
  localparam int STAT_EN      = 0;
  localparam int STAT_MS      = 1;
  localparam int STAT_ERR_LSB = 7;
  localparam int STAT_BUSY    = 13;
  localparam int GATE_LSB     = 8;
  localparam int SB_CLR_EN    = 0;
  localparam int SB_SET_EN    = 1;
  localparam int SB_CLR_MS    = 2;
  localparam int SB_SET_MS    = 3;

  typedef enum logic {ADDR_GATE = 1'b0, ADDR_STAT = 1'b1} addrT;

  typedef struct packed {
    logic             setEn;
    logic             clrEn;
    logic             setMs;
    logic             clrMs;
    logic [ERR_N-1:0] setErr;
    logic [ERR_N-1:0] clrErr;
  } strobeT;

  // strobe bit that sets error flag e
  function automatic int setPos(int e);
    case (e)
      E_MODE:  return 7;
      E_TXO:   return 12;
      E_RXO:   return 13;
      E_ABT:   return 14;
      E_TXU:   return 15;
      default: return 5;
    endcase
  endfunction

  // strobe bit that clears error flag e
  function automatic int clrPos(int e);
    case (e)
      E_MODE:  return 6;
      E_TXO:   return 8;
      E_RXO:   return 9;
      E_ABT:   return 10;
      E_TXU:   return 11;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/stflag_ctrl.sv
module stflag_ctrl
  import stflag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 addr,
  input  logic [DATA_W-1:0]    wrData,
  output strobeT               strobe,
  output logic [ERR_N-1:0]     gateMask
);
  localparam int GATE_N = ERR_N - 1;

  logic [GATE_N-1:0] errEn;
  logic              strobeWr;
  logic              gateWr;

  assign strobeWr = wrEn && (addr == ADDR_STAT);
  assign gateWr   = wrEn && (addr == ADDR_GATE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errEn <= '0;
    else if (gateWr) errEn <= wrData[GATE_LSB +: GATE_N];
  end

  // mode error has no enable and is always permitted
  assign gateMask = {errEn, 1'b1};

  assign strobe.setEn = strobeWr && wrData[SB_SET_EN];
  assign strobe.clrEn = strobeWr && wrData[SB_CLR_EN];
  assign strobe.setMs = strobeWr && wrData[SB_SET_MS];
  assign strobe.clrMs = strobeWr && wrData[SB_CLR_MS];

  for (genvar e = 0; e < ERR_N; e++) begin : gDecode
    assign strobe.setErr[e] = strobeWr && wrData[setPos(e)];
    assign strobe.clrErr[e] = strobeWr && wrData[clrPos(e)];
  end
endmodule

// File: rtl/stflag_dp.sv
module stflag_dp
  import stflag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  logic [ERR_N-1:0] hwEv,
  input  logic [ERR_N-1:0] gateMask,
  output logic             enBit,
  output logic             msBit,
  output logic [ERR_N-1:0] errFlags,
  output logic             errIrq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit <= 1'b0;
      msBit <= 1'b0;
    end else begin
      enBit <= (enBit | strobe.setEn) & ~strobe.clrEn;
      msBit <= (msBit | strobe.setMs) & ~strobe.clrMs;
    end
  end

  for (genvar e = 0; e < ERR_N; e++) begin : gFlag
    logic hwSet;
    assign hwSet = hwEv[e] & gateMask[e];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) errFlags[e] <= 1'b0;
      else errFlags[e] <= hwSet | ((errFlags[e] | strobe.setErr[e]) & ~strobe.clrErr[e]);
    end
  end

  assign errIrq = |errFlags;
endmodule

// File: rtl/status_strobe_regs.sv
module status_strobe_regs
  import stflag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              busyIn,
  input  logic              evRxUnder,
  input  logic              evTxUnder,
  input  logic              evAbort,
  input  logic              evRxOver,
  input  logic              evTxOver,
  input  logic              evMode,
  output logic              opMode,
  output logic              masterSel,
  output logic              errIrq
);
  strobeT           strobe;
  logic [ERR_N-1:0] gateMask;
  logic [ERR_N-1:0] errFlags;
  logic [ERR_N-1:0] hwEv;
  logic [DATA_W-1:0] statWord;
  logic [DATA_W-1:0] gateWord;

  assign hwEv = {evRxUnder, evTxUnder, evAbort, evRxOver, evTxOver, evMode};

  stflag_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strobe(strobe), .gateMask(gateMask)
  );

  stflag_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hwEv(hwEv), .gateMask(gateMask),
    .enBit(opMode), .msBit(masterSel), .errFlags(errFlags), .errIrq(errIrq)
  );

  always_comb begin
    statWord = '0;
    statWord[STAT_EN] = opMode;
    statWord[STAT_MS] = masterSel;
    statWord[STAT_ERR_LSB +: ERR_N] = errFlags;
    statWord[STAT_BUSY] = busyIn;
    gateWord = '0;
    gateWord[GATE_LSB +: ERR_N-1] = gateMask[ERR_N-1:1];
  end

  assign rdData = (addr == ADDR_STAT) ? statWord : gateWord;
endmodule

// File: rtl/stflag_chk.sv
module stflag_chk
  import stflag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              addr,
  input logic [DATA_W-1:0] wrData,
  input logic [ERR_N-1:0]  hwEv,
  input logic [ERR_N-1:0]  gateMask,
  input logic [ERR_N-1:0]  errFlags,
  input logic              opMode
);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr) |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!(wrEn && addr) && ((hwEv & gateMask) == '0)) |=> $stable(errFlags));

  a_r8_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    ((hwEv & gateMask) != '0) |=>
      ((errFlags & $past(hwEv & gateMask)) == $past(hwEv & gateMask)));

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr && wrData[6] && wrData[7] && !hwEv[E_MODE]) |=> !errFlags[E_MODE]);

  a_r2_clear_enable: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr && wrData[SB_CLR_EN]) |=> !opMode);
endmodule

bind status_strobe_regs stflag_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .hwEv(hwEv), .gateMask(gateMask), .errFlags(errFlags), .opMode(opMode)
);

// File: tb/tb_status_strobe_regs.sv
module tb_status_strobe_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        addr = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        busyIn = 1'b0;
  logic [5:0]  ev = '0;
  logic        opMode, masterSel, errIrq;
  int          nTests = 0;
  int          nFail = 0;

  always #4 clk = ~clk;

  // index 0 mode, 1 tx overflow, 2 rx overflow, 3 abort, 4 tx underflow, 5 rx underflow
  status_strobe_regs #(.DATA_W(16)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .busyIn(busyIn),
    .evRxUnder(ev[5]), .evTxUnder(ev[4]), .evAbort(ev[3]),
    .evRxOver(ev[2]), .evTxOver(ev[1]), .evMode(ev[0]),
    .opMode(opMode), .masterSel(masterSel), .errIrq(errIrq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic pulse(input logic [5:0] v);
    @(negedge clk); ev = v;
    @(negedge clk); ev = '0;
  endtask

  task automatic tReset();
    logic [15:0] d;
    rd(1'b1, d); chk("R1 status", d, 16'h0000);
    rd(1'b0, d); chk("R1 enable reg", d, 16'h0000);
    chk("R1 outputs", {13'd0, opMode, masterSel, errIrq}, 16'h0000);
  endtask

  task automatic tEnable();
    logic [15:0] d;
    wr(1'b1, 16'h0002); rd(1'b1, d);
    chk("R2 set enable status", d, 16'h0001); chk("R2 opMode", {15'd0, opMode}, 16'd1);
    wr(1'b1, 16'h0001); rd(1'b1, d);
    chk("R2 clear enable", d, 16'h0000); chk("R2 opMode off", {15'd0, opMode}, 16'd0);
  endtask

  task automatic tMaster();
    logic [15:0] d;
    wr(1'b1, 16'h0008); rd(1'b1, d);
    chk("R3 set master", d, 16'h0002); chk("R3 masterSel", {15'd0, masterSel}, 16'd1);
    wr(1'b1, 16'h0004); rd(1'b1, d);
    chk("R3 clear master", d, 16'h0000);
  endtask

  task automatic tErrStrobes();
    int setB[6] = '{7, 12, 13, 14, 15, 5};
    int clrB[6] = '{6, 8, 9, 10, 11, 4};
    int stB[6]  = '{7, 8, 9, 10, 11, 12};
    logic [15:0] d;
    for (int i = 0; i < 6; i++) begin
      wr(1'b1, 16'(1) << setB[i]); rd(1'b1, d);
      chk("R4 set error strobe", d, 16'(1) << stB[i]);
      chk("R9 irq on", {15'd0, errIrq}, 16'd1);
      wr(1'b1, 16'(1) << clrB[i]); rd(1'b1, d);
      chk("R4 clear error strobe", d, 16'h0000);
      chk("R9 irq off", {15'd0, errIrq}, 16'd0);
    end
  endtask

  task automatic tClearWins();
    logic [15:0] d;
    wr(1'b1, 16'h00C0); rd(1'b1, d); chk("R5 mode set+clear", d, 16'h0000);
    wr(1'b1, 16'h0003); rd(1'b1, d); chk("R5 enable set+clear", d, 16'h0000);
  endtask

  task automatic tMulti();
    logic [15:0] d;
    wr(1'b1, 16'h802A); rd(1'b1, d); chk("R6 multi set", d, 16'h1803);
    wr(1'b1, 16'h0F55); rd(1'b1, d); chk("R6 multi clear", d, 16'h0000);
  endtask

  task automatic tGate();
    logic [15:0] d;
    pulse(6'h3F); rd(1'b1, d); chk("R7 all gated off, mode passes", d, 16'h0080);
    wr(1'b1, 16'h0040);
    wr(1'b0, 16'h0200); pulse(6'h3F); rd(1'b1, d);
    chk("R7 only rx overflow enabled", d, 16'h0280);
    wr(1'b1, 16'h0F50);
    wr(1'b0, 16'hFFFF); rd(1'b0, d); chk("R10 enable readback", d, 16'h1F00);
    pulse(6'h3F); rd(1'b1, d); chk("R7 all enabled", d, 16'h1F80);
    chk("R9 irq with flags", {15'd0, errIrq}, 16'd1);
  endtask

  task automatic tSticky();
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rd(1'b1, d); chk("R11 held after pulse", d, 16'h1F80);
    wr(1'b1, 16'h0000); rd(1'b1, d); chk("R11 zero strobe no effect", d, 16'h1F80);
    wr(1'b1, 16'h0F50); rd(1'b1, d); chk("R11 cleared", d, 16'h0000);
  endtask

  task automatic tHwVsClear();
    logic [15:0] d;
    wr(1'b1, 16'h1000); rd(1'b1, d); chk("R8 pre-set tx overflow", d, 16'h0100);
    @(negedge clk); wrEn = 1'b1; addr = 1'b1; wrData = 16'h0100; ev = 6'h02;
    @(negedge clk); wrEn = 1'b0; wrData = '0; ev = '0;
    rd(1'b1, d); chk("R8 event beats clear", d, 16'h0100);
    wr(1'b1, 16'h0100); rd(1'b1, d); chk("R8 later clear", d, 16'h0000);
  endtask

  task automatic tBusy();
    logic [15:0] d;
    busyIn = 1'b1; rd(1'b1, d); chk("R10 busy bit", d, 16'h2000);
    busyIn = 1'b0; rd(1'b1, d); chk("R10 busy low", d, 16'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired (all requirements) actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tEnable();
    tMaster();
    tErrStrobes();
    tClearWins();
    tMulti();
    tGate();
    tSticky();
    tHwVsClear();
    tBusy();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule